// File: doc/BRIEF.md
# Aliased Floating-Point Register File

This block holds the floating-point operands of a processor core in one physical array of 64-bit entries. Software can reach that array at three granularities: 32-bit single, 64-bit double and 128-bit quad. Every access carries a 5-bit register specifier and a 2-bit size code. The block decodes the pair into the physical entries and halves it touches. A write changes exactly those bits. A read returns them right-justified on a 128-bit bus.

The array has 32 double entries. The lower 16 form the base bank, and the base bank is all a core sees while `ext_mode` is low. When `ext_mode` is high, the low bit of a double or quad specifier selects the upper bank instead of the base bank. This makes the upper 16 doubles reachable, but only at double or quad size. The block flags specifiers that are misaligned for their size and blocks writes through them. Reads are combinational, writes happen on the clock edge, and a read in the same cycle as a write already sees the new bits. There is one write port and a parameterised number of read ports.

Top module: `fp_alias_regfile`

## Requirements
- R1: After a synchronous active-low reset, every register at every size reads as zero.
- R2: Size code 0 (single) is legal for every specifier. Single n reads bits [63:32] of double entry n/2 when n is even and bits [31:0] when n is odd. It appears on rd_data[31:0], with the upper bits zero. Singles never reach entries 16–31.
- R3: With `ext_mode` low, size code 1 (double) is legal only for even specifiers. Specifier s then names entry s/2 and reads onto rd_data[63:0]. An odd specifier is illegal.
- R4: With `ext_mode` high, every double specifier is legal. Specifier s names entry 16·s[0] + s[4:1], so odd specifiers reach entries 16–31.
- R5: Size code 2 (quad) names the entry pair e, e+1, where e is even. Entry e appears on rd_data[127:64] and entry e+1 on rd_data[63:0]. With `ext_mode` low the specifier must be a multiple of 4 and e = s/2. With `ext_mode` high only s[1] must be 0, and e = 16·s[0] + s[4:1].
- R6: Size code 3 is illegal for every specifier.
- R7: A write through an illegal specifier raises `wr_illegal` in that cycle and changes no stored bit. `wr_illegal` is low whenever `wr_en` is low.
- R8: A single write changes only its 32-bit half. A double write changes only its entry. A quad write changes only its two entries. Write data bits above the access width are ignored.
- R9: While a legal write is applied, every read port whose access overlaps it returns the written bits in that same cycle.
- R10: A read through an illegal specifier raises its `rd_illegal` bit and returns all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_mode | input | 1 | High: double/quad specifiers can reach the upper bank |
| wr_en | input | 1 | Write request |
| wr_size | input | 2 | Write size: 0 single, 1 double, 2 quad, 3 reserved |
| wr_spec | input | 5 | Write register specifier |
| wr_data | input | 128 | Write data, right-justified |
| wr_illegal | output | 1 | Requested write was illegal and was dropped |
| rd_size | input | NUM_RD×2 | Per-port read size |
| rd_spec | input | NUM_RD×5 | Per-port read specifier |
| rd_data | output | NUM_RD×128 | Per-port read data, right-justified |
| rd_illegal | output | NUM_RD | Per-port illegal-specifier flag |

## Verification
A wrong alias mapping or a half-enable that fires when it should not does not stay hidden in the array. The next read of a neighbouring single, or of the enclosing double or quad, shows the corruption combinationally. Because of this, the bench re-reads every specifier at every size in both modes after each phase of writes. A fault in the bypass path shows up during the write cycle itself, one cycle before the array changes. A dropped or misrouted write shows up on the first read after the clock edge.

// File: rtl/fpra_pkg.sv
// Shared access-size encoding for the aliased floating-point register file.
// Assumes the size code is two bits wide and that code 3 is reserved.
package fpra_pkg;
    typedef enum logic [1:0] {
        ACC_SGL  = 2'd0,
        ACC_DBL  = 2'd1,
        ACC_QUAD = 2'd2,
        ACC_RSVD = 2'd3
    } acc_size_e;
endpackage

// File: rtl/fpra_decode.sv
// Specifier decoder. Turns (size, specifier, mode) into a legality bit, the
// index of the first double entry touched and the half-select used by singles.
// Assumes a quad's first entry is always even when the specifier is legal.
module fpra_decode
    import fpra_pkg::*;
#(
    parameter int SPEC_W = 5
) (
    input  logic              ext_mode,
    input  logic [1:0]        size,
    input  logic [SPEC_W-1:0] spec,
    output logic              legal,
    output logic [SPEC_W-1:0] idx,
    output logic              lo_half
);
    // Map the specifier onto the physical array by access size.
    always_comb begin
        legal   = 1'b0;
        idx     = {1'b0, spec[SPEC_W-1:1]};
        lo_half = spec[0];
        case (acc_size_e'(size))
            ACC_SGL: begin
                legal = 1'b1;
            end
            ACC_DBL: begin
                if (ext_mode) begin
                    legal = 1'b1;
                    idx   = {spec[0], spec[SPEC_W-1:1]};
                end else begin
                    legal = ~spec[0];
                end
            end
            ACC_QUAD: begin
                if (ext_mode) begin
                    legal = ~spec[1];
                    idx   = {spec[0], spec[SPEC_W-1:1]};
                end else begin
                    legal = (spec[1:0] == 2'b00);
                end
            end
            default: begin
                legal = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fpra_wsteer.sv
// Write steering. Produces one enable per 32-bit half of every double entry
// and the 64-bit data destined for each entry. Assumes the decoder has already
// checked legality; an illegal or idle write produces no enable at all.
module fpra_wsteer
    import fpra_pkg::*;
#(
    parameter int SPEC_W = 5,
    parameter int HALF_W = 32,
    parameter int NDBL   = 32,
    parameter int DBL_W  = 2 * HALF_W,
    parameter int QUAD_W = 4 * HALF_W
) (
    input  logic                       wr_go,
    input  logic [1:0]                 size,
    input  logic [SPEC_W-1:0]          idx,
    input  logic                       lo_half,
    input  logic [QUAD_W-1:0]          wdata,
    output logic [NDBL-1:0]            we_hi,
    output logic [NDBL-1:0]            we_lo,
    output logic [NDBL-1:0][DBL_W-1:0] wd
);
    for (genvar d = 0; d < NDBL; d++) begin : g_ent
        localparam logic [SPEC_W-1:0] DV = SPEC_W'(d);
        logic             hit_first;
        logic             hit_second;
        logic             e_hi;
        logic             e_lo;
        logic [DBL_W-1:0] dat;

        assign hit_first  = (idx == DV);
        assign hit_second = (idx[SPEC_W-1:1] == DV[SPEC_W-1:1]) && DV[0];

        // Select the enables and data for this entry from the access size.
        always_comb begin
            e_hi = 1'b0;
            e_lo = 1'b0;
            dat  = wdata[DBL_W-1:0];
            case (acc_size_e'(size))
                ACC_SGL: begin
                    e_hi = wr_go & hit_first & ~lo_half;
                    e_lo = wr_go & hit_first & lo_half;
                    dat  = {wdata[HALF_W-1:0], wdata[HALF_W-1:0]};
                end
                ACC_DBL: begin
                    e_hi = wr_go & hit_first;
                    e_lo = wr_go & hit_first;
                end
                ACC_QUAD: begin
                    e_hi = wr_go & (hit_first | hit_second);
                    e_lo = wr_go & (hit_first | hit_second);
                    dat  = hit_second ? wdata[DBL_W-1:0] : wdata[QUAD_W-1:DBL_W];
                end
                default: begin
                    e_hi = 1'b0;
                    e_lo = 1'b0;
                end
            endcase
        end

        assign we_hi[d] = e_hi;
        assign we_lo[d] = e_lo;
        assign wd[d]    = dat;
    end
endmodule

// File: rtl/fpra_bank.sv
// Physical storage of NDBL double entries, each split into two halves with
// their own write enable. Also produces a bypassed view in which halves being
// written this cycle already show their new data. Synchronous active-low reset
// clears every entry.
module fpra_bank #(
    parameter int HALF_W = 32,
    parameter int NDBL   = 32,
    parameter int DBL_W  = 2 * HALF_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NDBL-1:0]            we_hi,
    input  logic [NDBL-1:0]            we_lo,
    input  logic [NDBL-1:0][DBL_W-1:0] wd,
    output logic [NDBL-1:0][DBL_W-1:0] view
);
    logic [NDBL-1:0][DBL_W-1:0] mem;

    // Store the enabled halves, or clear everything during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else begin
            for (int i = 0; i < NDBL; i++) begin
                if (we_hi[i]) mem[i][DBL_W-1:HALF_W] <= wd[i][DBL_W-1:HALF_W];
                if (we_lo[i]) mem[i][HALF_W-1:0]     <= wd[i][HALF_W-1:0];
            end
        end
    end

    // Merge pending write halves over stored halves for same-cycle reads.
    always_comb begin
        for (int i = 0; i < NDBL; i++) begin
            view[i][DBL_W-1:HALF_W] = we_hi[i] ? wd[i][DBL_W-1:HALF_W] : mem[i][DBL_W-1:HALF_W];
            view[i][HALF_W-1:0]     = we_lo[i] ? wd[i][HALF_W-1:0]     : mem[i][HALF_W-1:0];
        end
    end
endmodule

// File: rtl/fpra_rport.sv
// One read port. Gathers a single half, one entry or an entry pair from the
// bypassed view and right-justifies it; an illegal access returns zero.
module fpra_rport
    import fpra_pkg::*;
#(
    parameter int SPEC_W = 5,
    parameter int HALF_W = 32,
    parameter int NDBL   = 32,
    parameter int DBL_W  = 2 * HALF_W,
    parameter int QUAD_W = 4 * HALF_W
) (
    input  logic [NDBL-1:0][DBL_W-1:0] view,
    input  logic [1:0]                 size,
    input  logic [SPEC_W-1:0]          idx,
    input  logic                       lo_half,
    input  logic                       legal,
    output logic [QUAD_W-1:0]          rdata
);
    logic [SPEC_W-1:0] idx_pair;
    assign idx_pair = {idx[SPEC_W-1:1], 1'b1};

    // Pick the aliased bits for the requested size.
    always_comb begin
        rdata = '0;
        if (legal) begin
            case (acc_size_e'(size))
                ACC_SGL:  rdata[HALF_W-1:0] = lo_half ? view[idx][HALF_W-1:0]
                                                      : view[idx][DBL_W-1:HALF_W];
                ACC_DBL:  rdata[DBL_W-1:0]  = view[idx];
                ACC_QUAD: rdata             = {view[idx], view[idx_pair]};
                default:  rdata             = '0;
            endcase
        end
    end
endmodule

// File: rtl/fp_alias_regfile.sv
// Aliased floating-point register file top. One write port and NUM_RD read
// ports share a 2**SPEC_W-entry double array; each access is decoded by size
// and mode. Reads are combinational with same-cycle write bypass; writes take
// effect at the rising clock edge. Synchronous active-low reset.
module fp_alias_regfile #(
    parameter int SPEC_W = 5,
    parameter int HALF_W = 32,
    parameter int NUM_RD = 2,
    localparam int NDBL   = 1 << SPEC_W,
    localparam int DBL_W  = 2 * HALF_W,
    localparam int QUAD_W = 4 * HALF_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ext_mode,
    input  logic                         wr_en,
    input  logic [1:0]                   wr_size,
    input  logic [SPEC_W-1:0]            wr_spec,
    input  logic [QUAD_W-1:0]            wr_data,
    output logic                         wr_illegal,
    input  logic [NUM_RD-1:0][1:0]       rd_size,
    input  logic [NUM_RD-1:0][SPEC_W-1:0] rd_spec,
    output logic [NUM_RD-1:0][QUAD_W-1:0] rd_data,
    output logic [NUM_RD-1:0]            rd_illegal
);
    logic                       w_legal;
    logic [SPEC_W-1:0]          w_idx;
    logic                       w_lo;
    logic [NDBL-1:0]            we_hi;
    logic [NDBL-1:0]            we_lo;
    logic [NDBL-1:0][DBL_W-1:0] wd;
    logic [NDBL-1:0][DBL_W-1:0] view;

    fpra_decode #(.SPEC_W(SPEC_W)) u_wdec (
        .ext_mode (ext_mode),
        .size     (wr_size),
        .spec     (wr_spec),
        .legal    (w_legal),
        .idx      (w_idx),
        .lo_half  (w_lo)
    );

    assign wr_illegal = wr_en & ~w_legal;

    fpra_wsteer #(.SPEC_W(SPEC_W), .HALF_W(HALF_W), .NDBL(NDBL)) u_steer (
        .wr_go   (wr_en & w_legal),
        .size    (wr_size),
        .idx     (w_idx),
        .lo_half (w_lo),
        .wdata   (wr_data),
        .we_hi   (we_hi),
        .we_lo   (we_lo),
        .wd      (wd)
    );

    fpra_bank #(.HALF_W(HALF_W), .NDBL(NDBL)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we_hi (we_hi),
        .we_lo (we_lo),
        .wd    (wd),
        .view  (view)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        logic              r_legal;
        logic [SPEC_W-1:0] r_idx;
        logic              r_lo;

        fpra_decode #(.SPEC_W(SPEC_W)) u_rdec (
            .ext_mode (ext_mode),
            .size     (rd_size[p]),
            .spec     (rd_spec[p]),
            .legal    (r_legal),
            .idx      (r_idx),
            .lo_half  (r_lo)
        );

        fpra_rport #(.SPEC_W(SPEC_W), .HALF_W(HALF_W), .NDBL(NDBL)) u_rport (
            .view    (view),
            .size    (rd_size[p]),
            .idx     (r_idx),
            .lo_half (r_lo),
            .legal   (r_legal),
            .rdata   (rd_data[p])
        );

        assign rd_illegal[p] = ~r_legal;
    end
endmodule

// File: rtl/fp_alias_regfile_chk.sv
// Port-level protocol checker for fp_alias_regfile, attached by bind.
// Observes read port 0 and the write port only.
module fp_alias_regfile_chk #(
    parameter int SPEC_W = 5,
    parameter int HALF_W = 32,
    parameter int NUM_RD = 2,
    localparam int QUAD_W = 4 * HALF_W
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          ext_mode,
    input logic                          wr_en,
    input logic [1:0]                    wr_size,
    input logic [SPEC_W-1:0]             wr_spec,
    input logic [QUAD_W-1:0]             wr_data,
    input logic                          wr_illegal,
    input logic [NUM_RD-1:0][1:0]        rd_size,
    input logic [NUM_RD-1:0][SPEC_W-1:0] rd_spec,
    input logic [NUM_RD-1:0][QUAD_W-1:0] rd_data,
    input logic [NUM_RD-1:0]             rd_illegal
);
    logic past_ok;

    // Mark cycles whose previous sample was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R6
    rsvd_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_size[0] == 2'd3) |-> rd_illegal[0]);

    // R3
    dbl_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && rd_size[0] == 2'd1 && rd_spec[0][0]) |-> rd_illegal[0]);

    // R5
    quad_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_size[0] == 2'd2 && rd_spec[0][1]) |-> rd_illegal[0]);

    // R2
    sgl_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_size[0] == 2'd0) |-> !rd_illegal[0]);

    // R10
    ill_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_illegal[0] |-> (rd_data[0] == '0));

    // R9
    dbl_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_illegal && wr_size == 2'd1 && rd_size[0] == 2'd1 &&
         rd_spec[0] == wr_spec) |-> (rd_data[0][2*HALF_W-1:0] == wr_data[2*HALF_W-1:0]));

    // R7
    wr_flag_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> !wr_illegal);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (!wr_en || wr_illegal) && $past(!wr_en || wr_illegal) &&
         $stable(rd_size[0]) && $stable(rd_spec[0]) && $stable(ext_mode))
        |-> $stable(rd_data[0]));
endmodule

bind fp_alias_regfile fp_alias_regfile_chk #(
    .SPEC_W (SPEC_W),
    .HALF_W (HALF_W),
    .NUM_RD (NUM_RD)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_mode   (ext_mode),
    .wr_en      (wr_en),
    .wr_size    (wr_size),
    .wr_spec    (wr_spec),
    .wr_data    (wr_data),
    .wr_illegal (wr_illegal),
    .rd_size    (rd_size),
    .rd_spec    (rd_spec),
    .rd_data    (rd_data),
    .rd_illegal (rd_illegal)
);

// File: tb/fp_alias_regfile_bench.sv
`timescale 1ns/1ps
module fp_alias_regfile_bench;
    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  ext_mode = 1'b0;
    logic                  wr_en = 1'b0;
    logic [1:0]            wr_size = '0;
    logic [4:0]            wr_spec = '0;
    logic [127:0]          wr_data = '0;
    logic                  wr_illegal;
    logic [1:0][1:0]       rd_size = '0;
    logic [1:0][4:0]       rd_spec = '0;
    logic [1:0][127:0]     rd_data;
    logic [1:0]            rd_illegal;

    int checks = 0;
    int errors = 0;
    logic [63:0] shd [32];

    fp_alias_regfile u_fp_alias_regfile (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode),
        .wr_en(wr_en), .wr_size(wr_size), .wr_spec(wr_spec), .wr_data(wr_data),
        .wr_illegal(wr_illegal),
        .rd_size(rd_size), .rd_spec(rd_spec), .rd_data(rd_data), .rd_illegal(rd_illegal)
    );

    always #4 clk = ~clk;

    // Expected mapping from the requirements: entry list, legality.
    task automatic decode_ref(input int sz, input int sp, input bit ext,
                              output bit ill, output int ent);
        ill = 1'b0;
        ent = sp / 2;
        case (sz)
            0: ill = 1'b0;
            1: begin
                if (ext) ent = (sp % 2) * 16 + sp / 2;
                else ill = (sp % 2) != 0;
            end
            2: begin
                if (ext) begin
                    ent = (sp % 2) * 16 + sp / 2;
                    ill = ((sp / 2) % 2) != 0;
                end else ill = (sp % 4) != 0;
            end
            default: ill = 1'b1;
        endcase
    endtask

    task automatic model_read(input int sz, input int sp, input bit ext,
                              output logic [127:0] d, output bit ill);
        int ent;
        decode_ref(sz, sp, ext, ill, ent);
        d = '0;
        if (!ill) begin
            if (sz == 0)      d[31:0] = (sp % 2) ? shd[ent][31:0] : shd[ent][63:32];
            else if (sz == 1) d[63:0] = shd[ent];
            else              d = {shd[ent], shd[ent+1]};
        end
    endtask

    task automatic model_write(input int sz, input int sp, input bit ext,
                               input logic [127:0] d);
        int ent;
        bit ill;
        decode_ref(sz, sp, ext, ill, ent);
        if (ill) return;
        if (sz == 0) begin
            if (sp % 2) shd[ent][31:0]  = d[31:0];
            else        shd[ent][63:32] = d[31:0];
        end else if (sz == 1) shd[ent] = d[63:0];
        else begin
            shd[ent]   = d[127:64];
            shd[ent+1] = d[63:0];
        end
    endtask

    function automatic string req_of(int sz, bit ext, bit ill);
        if (ill && sz != 3) return "R10";
        case (sz)
            0: return "R2";
            1: return ext ? "R4" : "R3";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check_port(input int p, input int sz, input int sp, input string tag);
        logic [127:0] exp_d;
        bit exp_ill;
        model_read(sz, sp, ext_mode, exp_d, exp_ill);
        checks++;
        if (rd_data[p] !== exp_d || rd_illegal[p] !== exp_ill) begin
            errors++;
            $display("FAIL %s port%0d size=%0d spec=%0d ext=%0d: got data=%h ill=%b exp data=%h ill=%b",
                     tag, p, sz, sp, ext_mode, rd_data[p], rd_illegal[p], exp_d, exp_ill);
        end
    endtask

    // Re-read every specifier at every size, both modes, both ports.
    task automatic sweep(input string phase);
        for (int e = 0; e < 2; e++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int sp = 0; sp < 32; sp++) begin
                    @(negedge clk);
                    ext_mode = e[0];
                    rd_size[0] = 2'(sz); rd_spec[0] = 5'(sp);
                    rd_size[1] = 2'(sz); rd_spec[1] = 5'(31 - sp);
                    #1;
                    check_port(0, sz, sp, phase.len() > 0 ? phase : req_of(sz, e[0], 1'b0));
                    check_port(1, sz, 31 - sp, phase.len() > 0 ? phase : req_of(sz, e[0], 1'b0));
                end
            end
        end
    endtask

    // Apply one write; check its flag (R7) and same-cycle bypass (R9).
    task automatic do_write(input int sz, input int sp, input bit ext, input logic [127:0] d);
        int ent;
        bit ill;
        decode_ref(sz, sp, ext, ill, ent);
        @(negedge clk);
        ext_mode = ext;
        wr_en = 1'b1; wr_size = 2'(sz); wr_spec = 5'(sp); wr_data = d;
        rd_size[0] = 2'(sz); rd_spec[0] = 5'(sp);
        rd_size[1] = 2'd1;
        rd_spec[1] = ext ? 5'(((ent % 16) * 2) + (ent / 16)) : 5'((ent % 16) * 2);
        model_write(sz, sp, ext, d);
        #1;
        checks++;
        if (wr_illegal !== ill) begin
            errors++;
            $display("FAIL R7 wr_illegal size=%0d spec=%0d: got %b exp %b", sz, sp, wr_illegal, ill);
        end
        if (!ill) begin
            check_port(0, sz, sp, "R9");
            if (ext || ent < 16) check_port(1, 1, int'(rd_spec[1]), "R9");
        end
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 32; i++) shd[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: everything reads zero after reset.
        sweep("R1");

        // R4: fill all 32 entries by double writes in extended mode; upper
        // 64 data bits are junk that must be ignored (R8).
        for (int ent = 0; ent < 32; ent++) begin
            logic [127:0] d;
            d = {64'hDEAD_BEEF_0BAD_F00D,
                 32'(ent * 32'h9E3779B1), 32'(ent * 32'h7F4A7C15 + 1)};
            do_write(1, ((ent % 16) * 2) + (ent / 16), 1'b1, d);
        end
        sweep("");

        // R7: illegal writes are flagged and dropped.
        do_write(1, 3, 1'b0, {4{32'hFFFF_FFFF}});
        do_write(2, 2, 1'b0, {4{32'hEEEE_EEEE}});
        do_write(3, 0, 1'b0, {4{32'hCCCC_CCCC}});
        do_write(2, 6, 1'b1, {4{32'hBBBB_BBBB}});
        do_write(3, 9, 1'b1, {4{32'hAAAA_AAAA}});
        sweep("R7");

        // R8: narrow writes touch only their aliased bits.
        do_write(0, 5, 1'b0, {96'hFFFF, 32'h1111_2222});
        do_write(0, 10, 1'b1, {96'h1, 32'h3333_4444});
        do_write(2, 1, 1'b1, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
        do_write(2, 8, 1'b0, 128'h5555_6666_7777_8888_9999_AAAA_BBBB_CCCC);
        do_write(1, 7, 1'b1, {64'hFFFF_FFFF_FFFF_FFFF, 64'h2468_ACE0_1357_9BDF});
        do_write(0, 31, 1'b0, {96'h0, 32'hCAFE_F00D});
        sweep("R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule